// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block stands in for a small serial EEPROM on a two-wire bus. The system presents the sampled clock and data line levels on two plain inputs. The block returns the level a master would read back from the data line. It also gives a drive-low enable for an open-drain pad. Storage is an internal byte array of up to 2 KB. Its contents live across resets.

The protocol is chosen by a parameter. The legacy variant takes a 7-bit word address and the R/W flag in the first byte. The one-byte variant uses a device byte followed by one address byte, and three device bits extend the address to 11 bits. The two-byte variant uses a device byte followed by two address bytes.

There is no byte state machine. One running bit-cycle counter is advanced on clock rising edges. ACK positions are fixed and loop-back points keep the count bounded. The block has no data stream at its edge, so it has no valid/ready handshake and no back-pressure. Both bus inputs are raw levels and are sampled on every clock.

Top module: `twi_eeprom_slave`

## Requirements
- R1: SDA falling while SCL is high arms the slave and sets the bit-cycle count to 0.
- R2: SDA rising while SCL is high disarms the slave. While disarmed, SCL edges are ignored, no ACK is driven, and the returned level equals the master's SDA level.
- R3: While armed, each SCL rising edge advances the bit-cycle count by one, subject to the loop-backs in R8 and R9. SDA is sampled on SCL falling edges, and a falling edge never changes the count.
- R4: While the count sits on an ACK slot, the returned level is 0 and the drive-low enable is 1. The ACK slots are cycles 9, 18 and 27 in the device-addressed variants and cycle 9 in the legacy variant.
- R5: In the device-addressed variants, cycles 1–8 carry the device byte MSB first, and its bit 0 is R/W (1 = read). In write mode the word address follows MSB first: one byte (cycles 10–17) or two bytes (cycles 10–17 high, 19–26 low).
- R6: In the one-byte variant, device byte bits 3:1 become word address bits 10:8 when the address byte completes at cycle 17.
- R7: In write mode, data bytes are shifted MSB first into the addressed byte. After each byte, only address bits 3:0 increment, so a 16-byte page wraps.
- R8: In device-addressed read mode, the count returns from 18 to 9 and the full address increments, so sequential reads cross page boundaries. In write mode the count loops 27→18 (one-byte variant) or 36→27 (two-byte variant).
- R9: In the legacy variant, the first byte is {address[6:0], R/W}, and the count loops 18→9. After each read byte the address increments modulo 128. After each written byte only address bits 1:0 increment, giving a 4-byte page.
- R10: In read mode, during cycles 10–17 the returned level is bit (17 − cycle) of the addressed byte, so the MSB goes out first.
- R11: Reset disarms the slave and clears the count, device byte and address. Memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw bus clock level |
| sda_i | input | 1 | Raw bus data level written by the master |
| sda_o | output | 1 | Data level returned to the master |
| sda_drive_low | output | 1 | Open-drain pull-down enable |

## Verification
The bench writes across a 16-byte page end and then reads the same span back. A design that wraps reads, or that increments writes freely, returns the wrong third byte. In the one-byte variant, two writes share a low address byte but use different device bits. A design that drops the device bits reads back the other block's data. In the legacy variant, a read runs past address 127 into address 0, and a write crosses a 4-byte page end, which exposes a wrong modulus in either direction. Two further checks confirm that the slave drives no ACK after a stop, and that memory keeps its data across a reset taken mid-transfer.

// File: rtl/twe_pkg.sv
package twe_pkg;
  typedef enum int {
    VAR_LEGACY   = 0,
    VAR_ONE_BYTE = 1,
    VAR_TWO_BYTE = 2
  } variant_e;

  localparam int CYC_W = 6;
  localparam logic [CYC_W-1:0] CYC_ACK_A   = 6'd9;
  localparam logic [CYC_W-1:0] CYC_ACK_B   = 6'd18;
  localparam logic [CYC_W-1:0] CYC_ACK_C   = 6'd27;
  localparam logic [CYC_W-1:0] CYC_WRAP_2  = 6'd36;
  localparam logic [CYC_W-1:0] CYC_RD_LAST = 6'd17;
  localparam logic [CYC_W-1:0] CYC_RD_FIRST = 6'd10;
endpackage

// File: rtl/twe_sync.sv
module twe_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-2:0], d[i]};
    end
    assign q[i] = sh[STAGES-1];
  end
endmodule

// File: rtl/twe_store.sv
module twe_store #(
  parameter int DEPTH = 2048,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic          bit_in,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= {mem[addr][6:0], bit_in};
  end

  assign rd_data = mem[addr];

  AST_WRITE_ADDR_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !$isunknown(addr)); // R7
endmodule

// File: rtl/twe_engine.sv
module twe_engine
  import twe_pkg::*;
#(
  parameter variant_e VARIANT = VAR_TWO_BYTE,
  parameter int       AW      = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic [7:0]    rd_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic          sda_o,
  output logic          sda_drive_low
);
  localparam bit LEGACY   = (VARIANT == VAR_LEGACY);
  localparam bit ONE_BYTE = (VARIANT == VAR_ONE_BYTE);
  localparam logic [CYC_W-1:0] DATA_FIRST = ONE_BYTE ? 6'd19 : 6'd28;
  localparam logic [CYC_W-1:0] BYTE_DONE  = ONE_BYTE ? 6'd26 : 6'd35;

  logic             scl_p, sda_p;
  logic             armed;
  logic [CYC_W-1:0] cyc, cyc_inc, cyc_nxt;
  logic [7:0]       dev;
  logic [AW-1:0]    addr, addr_shift_nxt;
  logic             rw, loop_rd, ack_slot, data_phase, rd_win, rd_bit;
  logic             start_c, stop_c, rise, fall;
  logic [2:0]       bit_idx;

  assign start_c = scl_p && scl_s && sda_p && !sda_s;
  assign stop_c  = scl_p && scl_s && !sda_p && sda_s;
  assign rise    = armed && !scl_p && scl_s;
  assign fall    = armed && scl_p && !scl_s;
  assign rw      = dev[0];

  // ACK slot decode differs per variant
  if (LEGACY) begin : g_ack_leg
    assign ack_slot   = (cyc == CYC_ACK_A);
    assign data_phase = (cyc > CYC_ACK_A);
  end else begin : g_ack_dev
    assign ack_slot   = (cyc == CYC_ACK_A) || (cyc == CYC_ACK_B) || (cyc == CYC_ACK_C);
    assign data_phase = (cyc >= DATA_FIRST);
  end

  // address shift: one-byte variant keeps 8 bits and splices device bits
  if (ONE_BYTE) begin : g_addr_one
    logic [AW-1:0] a_shift;
    always_comb begin
      a_shift = {addr[AW-2:0], sda_s};
      if (cyc == CYC_RD_LAST) addr_shift_nxt = AW'({dev[3:1], a_shift[7:0]});
      else                    addr_shift_nxt = AW'(a_shift[7:0]);
    end
  end else begin : g_addr_wide
    assign addr_shift_nxt = {addr[AW-2:0], sda_s};
  end

  always_comb begin
    cyc_inc = cyc + 6'd1;
    cyc_nxt = cyc_inc;
    loop_rd = 1'b0;
    if (LEGACY) begin
      if (cyc_inc == CYC_ACK_B) begin
        cyc_nxt = CYC_ACK_A;
        loop_rd = rw;
      end
    end else if (rw && cyc_inc == CYC_ACK_B) begin
      cyc_nxt = CYC_ACK_A;
      loop_rd = 1'b1;
    end else if (ONE_BYTE && cyc_inc == CYC_ACK_C) begin
      cyc_nxt = CYC_ACK_B;
    end else if (!ONE_BYTE && cyc_inc == CYC_WRAP_2) begin
      cyc_nxt = CYC_ACK_C;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
      armed <= 1'b0;
      cyc   <= '0;
      dev   <= '0;
      addr  <= '0;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
      if (start_c) begin
        armed <= 1'b1;
        cyc   <= '0;
      end else if (stop_c) begin
        armed <= 1'b0;
      end else if (rise) begin
        cyc <= cyc_nxt;
        if (loop_rd) begin
          if (LEGACY) dev  <= dev + 8'd2;
          else        addr <= addr + 1'b1;
        end
      end else if (fall && !ack_slot) begin
        if (LEGACY) begin
          if (data_phase) begin
            if (!rw && cyc == CYC_RD_LAST) dev <= {dev[7:3], dev[2:1] + 2'd1, dev[0]};
          end else begin
            dev <= {dev[6:0], sda_s};
          end
        end else begin
          if (data_phase) begin
            if (!rw && cyc == BYTE_DONE) addr <= {addr[AW-1:4], addr[3:0] + 4'd1};
          end else if (cyc > CYC_ACK_A) begin
            if (!rw) addr <= addr_shift_nxt;
          end else begin
            dev <= {dev[6:0], sda_s};
          end
        end
      end
    end
  end

  assign mem_we   = fall && !ack_slot && data_phase && !rw;
  assign mem_addr = LEGACY ? AW'(dev[7:1]) : addr;

  assign rd_win  = rw && (cyc >= CYC_RD_FIRST) && (cyc <= CYC_RD_LAST);
  assign bit_idx = 3'(CYC_RD_LAST - cyc);
  assign rd_bit  = rd_data[bit_idx];

  always_comb begin
    if (!armed)        sda_o = sda_s;
    else if (ack_slot) sda_o = 1'b0;
    else if (rd_win)   sda_o = rd_bit;
    else               sda_o = sda_s;
  end
  assign sda_drive_low = armed && (ack_slot || (rd_win && !rd_bit));

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (armed && cyc == '0)); // R1
  AST_STOP_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !armed); // R2
  AST_FALL_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> $stable(cyc)); // R3
  AST_CYC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (cyc <= CYC_WRAP_2)); // R8
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
  import twe_pkg::*;
#(
  parameter variant_e VARIANT     = VAR_TWO_BYTE,
  parameter int       MEM_BYTES   = 2048,
  parameter int       SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic sda_drive_low
);
  localparam int AW = $clog2(MEM_BYTES);

  logic [1:0]    bus_s;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    rd_data;

  twe_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({scl_i, sda_i}),
    .q    (bus_s)
  );

  twe_engine #(.VARIANT(VARIANT), .AW(AW)) u_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_s        (bus_s[1]),
    .sda_s        (bus_s[0]),
    .rd_data      (rd_data),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .sda_o        (sda_o),
    .sda_drive_low(sda_drive_low)
  );

  twe_store #(.DEPTH(MEM_BYTES), .AW(AW)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (mem_we),
    .addr   (mem_addr),
    .bit_in (bus_s[0]),
    .rd_data(rd_data)
  );
endmodule

// File: tb/twi_eeprom_slave_tb_top.sv
module twi_eeprom_slave_tb_top;
  import twe_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_b [3];
  logic sda_b [3];
  logic so_b  [3];
  logic pl_b  [3];
  int   n_chk = 0;
  int   n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twi_eeprom_slave #(.VARIANT(VAR_TWO_BYTE), .MEM_BYTES(2048)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_b[2]), .sda_i(sda_b[2]),
    .sda_o(so_b[2]), .sda_drive_low(pl_b[2]));
  twi_eeprom_slave #(.VARIANT(VAR_ONE_BYTE), .MEM_BYTES(2048)) dut_v1_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_b[1]), .sda_i(sda_b[1]),
    .sda_o(so_b[1]), .sda_drive_low(pl_b[1]));
  twi_eeprom_slave #(.VARIANT(VAR_LEGACY), .MEM_BYTES(128)) dut_v0_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_b[0]), .sda_i(sda_b[0]),
    .sda_o(so_b[0]), .sda_drive_low(pl_b[0]));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic phase();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start(input int k);
    sda_b[k] = 1'b1; phase();
    scl_b[k] = 1'b1; phase();
    sda_b[k] = 1'b0; phase();
    scl_b[k] = 1'b0; phase();
  endtask

  task automatic bus_stop(input int k);
    sda_b[k] = 1'b0; phase();
    scl_b[k] = 1'b1; phase();
    sda_b[k] = 1'b1; phase();
  endtask

  task automatic clk_bit(input int k, input logic b, output logic seen);
    sda_b[k] = b; phase();
    scl_b[k] = 1'b1; phase();
    seen = so_b[k];
    scl_b[k] = 1'b0; phase();
  endtask

  task automatic send_byte(input int k, input logic [7:0] v, input string tag);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(k, v[i], s);
    clk_bit(k, 1'b1, s);
    check(tag, {31'd0, s}, 32'd0);
  endtask

  task automatic recv_byte(input int k, input logic last, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(k, 1'b1, s);
      v[i] = s;
    end
    clk_bit(k, last, s);
  endtask

  task automatic dev_setup(input int k, input logic [7:0] dv, input logic [15:0] a);
    bus_start(k);
    send_byte(k, dv, "R1 R4 R5 device ack");
    if (k == 2) send_byte(k, a[15:8], "R4 R5 address-high ack");
    send_byte(k, a[7:0], "R4 R5 address-low ack");
  endtask

  task automatic dev_write(input int k, input logic [7:0] dv, input logic [15:0] a,
                           input logic [31:0] data, input int n);
    dev_setup(k, dv, a);
    for (int j = 0; j < n; j++) send_byte(k, data[31-8*j -: 8], "R4 R7 data ack");
    bus_stop(k);
  endtask

  task automatic dev_read(input int k, input logic [7:0] dv, input logic [15:0] a,
                          input logic [31:0] exp, input int n, input string tag);
    logic [7:0] got;
    dev_setup(k, dv, a);
    bus_start(k);
    send_byte(k, dv | 8'h01, "R4 R5 read device ack");
    for (int j = 0; j < n; j++) begin
      recv_byte(k, (j == n-1), got);
      check(tag, {24'd0, got}, {24'd0, exp[31-8*j -: 8]});
    end
    bus_stop(k);
  endtask

  task automatic leg_write(input logic [6:0] a, input logic [31:0] data, input int n);
    bus_start(0);
    send_byte(0, {a, 1'b0}, "R4 R9 legacy address ack");
    for (int j = 0; j < n; j++) send_byte(0, data[31-8*j -: 8], "R4 R9 legacy data ack");
    bus_stop(0);
  endtask

  task automatic leg_read(input logic [6:0] a, input logic [31:0] exp, input int n, input string tag);
    logic [7:0] got;
    bus_start(0);
    send_byte(0, {a, 1'b1}, "R4 R9 legacy read ack");
    for (int j = 0; j < n; j++) begin
      recv_byte(0, (j == n-1), got);
      check(tag, {24'd0, got}, {24'd0, exp[31-8*j -: 8]});
    end
    bus_stop(0);
  endtask

  task automatic test_reset_idle();
    for (int k = 0; k < 3; k++) begin
      check("R11 idle level after reset", {31'd0, so_b[k]}, 32'd1);
      check("R11 no pull after reset", {31'd0, pl_b[k]}, 32'd0);
    end
    scl_b[2] = 1'b0; phase();
    sda_b[2] = 1'b0; phase();
    check("R2 idle output follows SDA low", {31'd0, so_b[2]}, 32'd0);
    check("R2 idle no pull", {31'd0, pl_b[2]}, 32'd0);
    sda_b[2] = 1'b1; phase();
    scl_b[2] = 1'b1; phase();
  endtask

  task automatic test_two_byte();
    dev_write(2, 8'hA0, 16'h0130, 32'h44000000, 1);
    dev_write(2, 8'hA0, 16'h012E, 32'h11223300, 3);
    dev_read(2, 8'hA0, 16'h012E, 32'h11224400, 3, "R3 R8 R10 sequential read crosses page");
    dev_read(2, 8'hA0, 16'h0120, 32'h33000000, 1, "R7 write page wrap");
  endtask

  task automatic test_one_byte();
    dev_write(1, 8'hA2, 16'h0045, 32'h77000000, 1);
    dev_write(1, 8'hA6, 16'h0045, 32'h5AC30000, 2);
    dev_read(1, 8'hA6, 16'h0045, 32'h5AC30000, 2, "R6 R10 block 3 readback");
    dev_read(1, 8'hA2, 16'h0045, 32'h77000000, 1, "R6 block 1 readback");
  endtask

  task automatic test_legacy();
    leg_write(7'h00, 32'h99000000, 1);
    leg_write(7'h7E, 32'h10203000, 3);
    leg_read(7'h7F, 32'h20990000, 2, "R9 read wraps modulo 128");
    leg_read(7'h7C, 32'h30000000, 1, "R9 write 4-byte page wrap");
  endtask

  task automatic test_after_stop();
    logic s;
    bus_start(2);
    send_byte(2, 8'hA0, "R1 R4 device ack");
    bus_stop(2);
    scl_b[2] = 1'b0; phase();
    for (int i = 0; i < 9; i++) clk_bit(2, 1'b1, s);
    check("R2 no ack after stop", {31'd0, s}, 32'd1);
    check("R2 no pull after stop", {31'd0, pl_b[2]}, 32'd0);
  endtask

  task automatic test_reset_mid();
    logic s;
    bus_start(2);
    for (int i = 7; i >= 0; i--) clk_bit(2, 1'b0, s);
    sda_b[2] = 1'b1; phase();
    scl_b[2] = 1'b1; phase();
    check("R4 ack slot drives low", {31'd0, so_b[2]}, 32'd0);
    check("R4 ack slot pull enable", {31'd0, pl_b[2]}, 32'd1);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    phase();
    check("R11 reset disarms mid-transfer", {31'd0, so_b[2]}, 32'd1);
    check("R11 reset releases pull", {31'd0, pl_b[2]}, 32'd0);
    scl_b[2] = 1'b0; phase();
    dev_read(2, 8'hA0, 16'h012E, 32'h11000000, 1, "R11 memory kept across reset");
  endtask

  bit done = 1'b0;

  initial begin
    for (int k = 0; k < 3; k++) begin
      scl_b[k] = 1'b1;
      sda_b[k] = 1'b1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    phase();
    test_reset_idle();
    test_two_byte();
    test_one_byte();
    test_legacy();
    test_after_stop();
    test_reset_mid();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule